// File: doc/BRIEF.md
# Discharge-Lamp Ballast Mode Supervisor

This block decides which operating mode a discharge-lamp ballast is in and turns that mode into enable and clear signals for the rest of the controller. It reads digital comparator flags for the supply rail, the lamp-voltage window, the power and current loop levels and the reset pin. It also reads one fault request that the external fault-counter blocks raise. From these it moves between five modes: lockout, ignition, normal run, buck-off and latched fault.

Every flag is asynchronous to the block clock. Each one passes through its own two-flop synchronizer before the mode logic sees it. Mode and outputs come from one register stage. The bridge, buck, ignition-timer and counter enables, and the counter clear levels, therefore change in the same cycle as the mode code. A system reset forces lockout from any mode.

Top module: `ballast_supervisor`

## Requirements
- R1: While `rst_n` is low, the block is in lockout (mode 0). All enables are 0, both counter clears are 1 and the fault latch output is 0. This holds whatever mode was active before.
- R2: Each flag passes through a two-flop synchronizer. A flag change driven between two rising edges shows on `mode_o` after the third rising edge, and not before.
- R3: A synchronized supply-below-off flag moves every mode to lockout on the next edge. It takes priority over every other condition.
- R4: Lockout moves to ignition only when supply-above-on, lamp-above-overvoltage and reset-pin-below-low are all 1. In every other case it stays in lockout, and the fault request is ignored there.
- R5: In ignition or run, a fault request moves the block to fault mode. This takes priority over the buck-off conditions.
- R6: In ignition or run, the block enters buck-off when lamp-above-overvoltage is 1, power-loop-ok is 0, or current-loop-min is 0.
- R7: In ignition or run with no fault and no buck-off cause, the block is in ignition when lamp-above-2/5 is 1 and in run when it is 0.
- R8: Buck-off leaves only when lamp-above-overvoltage is 0, power-loop-ok is 1 and current-loop-run is 1. The exit goes to ignition if lamp-above-2/5 is 1 and to run if it is 0. A fault request in buck-off moves the block to fault mode.
- R9: Fault mode ignores every flag except two. Reset-pin-above-high moves it to lockout, and supply-below-off moves it to lockout (R3). `fault_latched_o` is 1 exactly in fault mode.
- R10: The bridge and counter enables are 1 in ignition, run and buck-off. The buck enable is 1 in ignition and run. The ignition-timer enable is 1 only in ignition.
- R11: `fault_cnt_clr_o` is 1 in lockout and fault. `good_cnt_clr_o` is 1 in lockout, fault and ignition. Both clears are also 1 for the single cycle in which buck-off is entered.
- R12: `mode_o` codes are 0 for lockout, 1 for ignition, 2 for run, 3 for buck-off and 4 for fault. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces lockout |
| supply_on_i | input | 1 | Supply above the turn-on threshold |
| supply_off_i | input | 1 | Supply below the turn-off threshold |
| lamp_ov_i | input | 1 | Lamp voltage above the overvoltage level |
| lamp_2of5_i | input | 1 | Lamp voltage above 2/5 of the overvoltage level |
| pwr_ok_i | input | 1 | Power loop level above 0.2 V |
| cur_min_i | input | 1 | Current loop level above 0.2 V |
| cur_run_i | input | 1 | Current loop level above 0.5 V |
| rpin_lo_i | input | 1 | Reset pin below its lower threshold |
| rpin_hi_i | input | 1 | Reset pin above its upper threshold |
| fault_req_i | input | 1 | Fault request from the counter blocks |
| bridge_en_o | output | 1 | Full-bridge oscillator enable |
| buck_en_o | output | 1 | Buck stage enable |
| ign_en_o | output | 1 | Ignition timer enable |
| cnt_en_o | output | 1 | Fault counter and time-base enable |
| fault_cnt_clr_o | output | 1 | Clear level for the fault counters |
| good_cnt_clr_o | output | 1 | Clear level for the good counter |
| fault_latched_o | output | 1 | Fault latch state |
| mode_o | output | 3 | Current mode code |

## Verification
On every cycle the assertions check four things. Supply loss always reaches lockout. Lockout and fault hold unless their exit conditions are present. Fault and buck-off causes in ignition or run reach their target mode. The enable and clear outputs never disagree with one another, and the mode code stays in range. Other behaviour only the bench's scenarios can show. This covers the three-edge synchronizer latency and the one-cycle clear pulse on buck-off entry. It also covers where buck-off exits go, and the full mode walk under sweeps of every flag combination, compared against an independent reference model.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

    localparam int FLAG_W  = 10;
    localparam int F_VON   = 0;
    localparam int F_VOFF  = 1;
    localparam int F_OV    = 2;
    localparam int F_2OF5  = 3;
    localparam int F_PWR   = 4;
    localparam int F_CMIN  = 5;
    localparam int F_CRUN  = 6;
    localparam int F_RLO   = 7;
    localparam int F_RHI   = 8;
    localparam int F_FAULT = 9;

    typedef enum logic [2:0] {
        M_LOCKOUT = 3'd0,
        M_IGNITE  = 3'd1,
        M_RUN     = 3'd2,
        M_BUCKOFF = 3'd3,
        M_FAULT   = 3'd4
    } mode_e;

    typedef struct packed {
        logic bridge_en;
        logic buck_en;
        logic ign_en;
        logic cnt_en;
        logic fault_clr;
        logic good_clr;
        logic latched;
    } ctrl_t;

    typedef struct packed {
        mode_e mode;
        ctrl_t ctrl;
    } sup_state_t;

    localparam ctrl_t CTRL_RESET = '{
        bridge_en: 1'b0, buck_en: 1'b0, ign_en: 1'b0, cnt_en: 1'b0,
        fault_clr: 1'b1, good_clr: 1'b1, latched: 1'b0
    };

endpackage

// File: rtl/ballast_sync.sv
module ballast_sync #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ballast_mode_next.sv
module ballast_mode_next
    import ballast_pkg::*;
(
    input  mode_e             cur_i,
    input  logic [FLAG_W-1:0] flags_i,
    output mode_e             nxt_o
);

    logic  buck_trip;
    logic  buck_clear;
    logic  lockout_exit;
    mode_e drive_pick;

    always_comb begin
        buck_trip    = flags_i[F_OV] | ~flags_i[F_PWR] | ~flags_i[F_CMIN];
        buck_clear   = ~flags_i[F_OV] & flags_i[F_PWR] & flags_i[F_CRUN];
        lockout_exit = flags_i[F_VON] & flags_i[F_OV] & flags_i[F_RLO];
        drive_pick   = flags_i[F_2OF5] ? M_IGNITE : M_RUN;

        nxt_o = cur_i;
        if (flags_i[F_VOFF]) begin
            nxt_o = M_LOCKOUT;
        end else begin
            unique case (cur_i)
                M_LOCKOUT: if (lockout_exit) nxt_o = M_IGNITE;
                M_IGNITE, M_RUN: begin
                    if (flags_i[F_FAULT])  nxt_o = M_FAULT;
                    else if (buck_trip)    nxt_o = M_BUCKOFF;
                    else                   nxt_o = drive_pick;
                end
                M_BUCKOFF: begin
                    if (flags_i[F_FAULT])  nxt_o = M_FAULT;
                    else if (buck_clear)   nxt_o = drive_pick;
                end
                M_FAULT:   if (flags_i[F_RHI]) nxt_o = M_LOCKOUT;
                default:   nxt_o = M_LOCKOUT;
            endcase
        end
    end

endmodule

// File: rtl/ballast_ctrl_dec.sv
module ballast_ctrl_dec
    import ballast_pkg::*;
(
    input  mode_e cur_i,
    input  mode_e nxt_i,
    output ctrl_t ctrl_o
);

    logic active;
    logic held;
    logic buck_entry;

    always_comb begin
        active     = (nxt_i == M_IGNITE) | (nxt_i == M_RUN) | (nxt_i == M_BUCKOFF);
        held       = (nxt_i == M_LOCKOUT) | (nxt_i == M_FAULT);
        buck_entry = (nxt_i == M_BUCKOFF) & (cur_i != M_BUCKOFF);

        ctrl_o.bridge_en = active;
        ctrl_o.cnt_en    = active;
        ctrl_o.buck_en   = (nxt_i == M_IGNITE) | (nxt_i == M_RUN);
        ctrl_o.ign_en    = (nxt_i == M_IGNITE);
        ctrl_o.fault_clr = held | buck_entry;
        ctrl_o.good_clr  = held | (nxt_i == M_IGNITE) | buck_entry;
        ctrl_o.latched   = (nxt_i == M_FAULT);
    end

endmodule

// File: rtl/ballast_supervisor.sv
module ballast_supervisor
    import ballast_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_on_i,
    input  logic       supply_off_i,
    input  logic       lamp_ov_i,
    input  logic       lamp_2of5_i,
    input  logic       pwr_ok_i,
    input  logic       cur_min_i,
    input  logic       cur_run_i,
    input  logic       rpin_lo_i,
    input  logic       rpin_hi_i,
    input  logic       fault_req_i,
    output logic       bridge_en_o,
    output logic       buck_en_o,
    output logic       ign_en_o,
    output logic       cnt_en_o,
    output logic       fault_cnt_clr_o,
    output logic       good_cnt_clr_o,
    output logic       fault_latched_o,
    output logic [2:0] mode_o
);

    logic [FLAG_W-1:0] flags_a;
    logic [FLAG_W-1:0] flags_s;
    mode_e             mode_nxt;
    ctrl_t             ctrl_nxt;
    sup_state_t        st_d;
    sup_state_t        st_q;

    always_comb begin
        flags_a          = '0;
        flags_a[F_VON]   = supply_on_i;
        flags_a[F_VOFF]  = supply_off_i;
        flags_a[F_OV]    = lamp_ov_i;
        flags_a[F_2OF5]  = lamp_2of5_i;
        flags_a[F_PWR]   = pwr_ok_i;
        flags_a[F_CMIN]  = cur_min_i;
        flags_a[F_CRUN]  = cur_run_i;
        flags_a[F_RLO]   = rpin_lo_i;
        flags_a[F_RHI]   = rpin_hi_i;
        flags_a[F_FAULT] = fault_req_i;
    end

    ballast_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_a),
        .sync_o  (flags_s)
    );

    ballast_mode_next u_next (
        .cur_i   (st_q.mode),
        .flags_i (flags_s),
        .nxt_o   (mode_nxt)
    );

    ballast_ctrl_dec u_dec (
        .cur_i  (st_q.mode),
        .nxt_i  (mode_nxt),
        .ctrl_o (ctrl_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_nxt;
        st_d.ctrl = ctrl_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= M_LOCKOUT;
            st_q.ctrl <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bridge_en_o     = st_q.ctrl.bridge_en;
    assign buck_en_o       = st_q.ctrl.buck_en;
    assign ign_en_o        = st_q.ctrl.ign_en;
    assign cnt_en_o        = st_q.ctrl.cnt_en;
    assign fault_cnt_clr_o = st_q.ctrl.fault_clr;
    assign good_cnt_clr_o  = st_q.ctrl.good_clr;
    assign fault_latched_o = st_q.ctrl.latched;
    assign mode_o          = st_q.mode;

endmodule

// File: rtl/ballast_supervisor_chk.sv
module ballast_supervisor_chk
    import ballast_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FLAG_W-1:0] flags_s,
    input logic [2:0]        mode_o,
    input logic              bridge_en_o,
    input logic              buck_en_o,
    input logic              fault_cnt_clr_o,
    input logic              good_cnt_clr_o,
    input logic              fault_latched_o
);

    logic driving;
    assign driving = (mode_o == 3'd1) || (mode_o == 3'd2);

    assert_supply_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_s[F_VOFF] |=> mode_o == 3'd0);

    assert_lockout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) && !(flags_s[F_VON] && flags_s[F_OV] && flags_s[F_RLO])
        |=> mode_o == 3'd0);

    assert_fault_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        driving && !flags_s[F_VOFF] && flags_s[F_FAULT] |=> mode_o == 3'd4);

    assert_buck_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        driving && !flags_s[F_VOFF] && !flags_s[F_FAULT] && flags_s[F_OV]
        |=> mode_o == 3'd3);

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) && !flags_s[F_VOFF] && !flags_s[F_RHI] |=> mode_o == 3'd4);

    assert_buck_needs_bridge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        buck_en_o |-> bridge_en_o);

    assert_latch_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched_o |-> fault_cnt_clr_o && good_cnt_clr_o && !bridge_en_o);

    assert_code_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

endmodule

bind ballast_supervisor ballast_supervisor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .flags_s         (flags_s),
    .mode_o          (mode_o),
    .bridge_en_o     (bridge_en_o),
    .buck_en_o       (buck_en_o),
    .fault_cnt_clr_o (fault_cnt_clr_o),
    .good_cnt_clr_o  (good_cnt_clr_o),
    .fault_latched_o (fault_latched_o)
);

// File: tb/ballast_supervisor_bench.sv
module ballast_supervisor_bench;

    localparam int VON = 0, VOFF = 1, OV = 2, TWO5 = 3, PWR = 4;
    localparam int CMIN = 5, CRUN = 6, RLO = 7, RHI = 8, FLT = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] fl = '0;
    logic       bridge_en, buck_en, ign_en, cnt_en, fclr, gclr, latched;
    logic [2:0] mode;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       cmp_en = 1'b0;

    always #2.5 clk = ~clk;

    ballast_supervisor u_ballast_supervisor (
        .clk (clk), .rst_n (rst_n),
        .supply_on_i (fl[VON]), .supply_off_i (fl[VOFF]),
        .lamp_ov_i (fl[OV]), .lamp_2of5_i (fl[TWO5]),
        .pwr_ok_i (fl[PWR]), .cur_min_i (fl[CMIN]), .cur_run_i (fl[CRUN]),
        .rpin_lo_i (fl[RLO]), .rpin_hi_i (fl[RHI]), .fault_req_i (fl[FLT]),
        .bridge_en_o (bridge_en), .buck_en_o (buck_en), .ign_en_o (ign_en),
        .cnt_en_o (cnt_en), .fault_cnt_clr_o (fclr), .good_cnt_clr_o (gclr),
        .fault_latched_o (latched), .mode_o (mode)
    );

    // Reference model built from the requirements (R2..R9)
    function automatic logic [2:0] ref_next(input logic [2:0] m, input logic [9:0] f);
        if (f[VOFF]) return 3'd0;
        case (m)
            3'd0: return (f[VON] && f[OV] && f[RLO]) ? 3'd1 : 3'd0;
            3'd1, 3'd2: begin
                if (f[FLT]) return 3'd4;
                if (f[OV] || !f[PWR] || !f[CMIN]) return 3'd3;
                return f[TWO5] ? 3'd1 : 3'd2;
            end
            3'd3: begin
                if (f[FLT]) return 3'd4;
                if (!f[OV] && f[PWR] && f[CRUN]) return f[TWO5] ? 3'd1 : 3'd2;
                return 3'd3;
            end
            3'd4: return f[RHI] ? 3'd0 : 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    logic [9:0] m_s1, m_s2;
    logic [2:0] m_mode, m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_mode <= 3'd0; m_prev <= 3'd0;
        end else begin
            m_s1 <= fl; m_s2 <= m_s1;
            m_prev <= m_mode;
            m_mode <= ref_next(m_mode, m_s2);
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Continuous comparison against the reference (R10, R11, R12)
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            logic act, drv, hold, entry;
            act   = (m_mode == 3'd1) || (m_mode == 3'd2) || (m_mode == 3'd3);
            drv   = (m_mode == 3'd1) || (m_mode == 3'd2);
            hold  = (m_mode == 3'd0) || (m_mode == 3'd4);
            entry = (m_mode == 3'd3) && (m_prev != 3'd3);
            check(mode == m_mode, "R12 mode code", mode, m_mode);
            check(bridge_en == act && cnt_en == act, "R10 bridge/counter enable",
                  {bridge_en, cnt_en}, {act, act});
            check(buck_en == drv, "R10 buck enable", buck_en, drv);
            check(ign_en == (m_mode == 3'd1), "R10 ignition enable", ign_en, m_mode == 3'd1);
            check(fclr == (hold || entry), "R11 fault clear", fclr, hold || entry);
            check(gclr == (hold || entry || m_mode == 3'd1), "R11 good clear",
                  gclr, hold || entry || m_mode == 3'd1);
            check(latched == (m_mode == 3'd4), "R9 fault latch", latched, m_mode == 3'd4);
        end
    end

    task automatic drive(input logic [9:0] v, input int n);
        fl = v;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [9:0] b(input int i);
        return 10'(1) << i;
    endfunction

    task automatic run_all();
        logic [9:0] ok_run;
        ok_run = b(VON) | b(PWR) | b(CMIN) | b(CRUN);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mode == 3'd0, "R1 reset mode", mode, 0);
        check({bridge_en, buck_en, ign_en, cnt_en, latched} == 5'b0, "R1 reset enables",
              {bridge_en, buck_en, ign_en, cnt_en, latched}, 0);
        check(fclr && gclr, "R1 reset clears", {fclr, gclr}, 3);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // R4 negative: reset pin not low keeps lockout, fault ignored there
        drive(ok_run | b(OV) | b(FLT), 5);
        check(mode == 3'd0, "R4 lockout hold", mode, 0);

        // R2 latency then R4 exit, R6 immediate buck-off due to overvoltage
        drive(ok_run | b(OV) | b(RLO) | b(TWO5), 2);
        check(mode == 3'd0, "R2 no change before third edge", mode, 0);
        @(negedge clk);
        check(mode == 3'd1, "R2 R4 ignition on third edge", mode, 1);
        @(negedge clk);
        check(mode == 3'd3, "R6 overvoltage trip", mode, 3);
        check(fclr && gclr, "R11 entry pulse", {fclr, gclr}, 3);
        @(negedge clk);
        check(!fclr && !gclr, "R11 pulse one cycle", {fclr, gclr}, 0);

        // R8 exit to ignition, R7 run select
        drive(ok_run | b(TWO5), 3);
        check(mode == 3'd1, "R8 exit to ignition", mode, 1);
        drive(ok_run, 3);
        check(mode == 3'd2, "R7 run select", mode, 2);
        check(buck_en && !ign_en, "R10 run enables", {buck_en, ign_en}, 2);

        // R6 power loop low; R8 hold without current-run level; exit to run
        drive(ok_run & ~b(PWR), 3);
        check(mode == 3'd3, "R6 power loop trip", mode, 3);
        drive(ok_run & ~b(CRUN), 3);
        check(mode == 3'd3, "R8 buck-off hold", mode, 3);
        drive(ok_run, 3);
        check(mode == 3'd2, "R8 exit to run", mode, 2);
        drive(ok_run & ~b(CMIN), 3);
        check(mode == 3'd3, "R6 current loop trip", mode, 3);
        drive(ok_run, 3);

        // R5 fault priority over buck-off cause
        drive(ok_run | b(OV) | b(FLT), 3);
        check(mode == 3'd4, "R5 fault priority", mode, 4);
        check(latched && !bridge_en, "R9 latch set", {latched, bridge_en}, 2);
        drive(ok_run | b(OV) | b(RLO) | b(TWO5), 6);
        check(mode == 3'd4, "R9 fault ignores flags", mode, 4);
        drive(ok_run | b(RHI), 3);
        check(mode == 3'd0, "R9 reset pin exit", mode, 0);

        // R3 supply loss over fault request
        drive(ok_run | b(OV) | b(RLO), 4);
        drive(ok_run, 3);
        check(mode == 3'd2, "R3 setup run", mode, 2);
        drive(ok_run | b(VOFF) | b(FLT), 3);
        check(mode == 3'd0, "R3 supply loss", mode, 0);

        // R1 async reset from fault
        drive(ok_run | b(OV) | b(RLO), 4);
        drive(ok_run | b(FLT), 3);
        check(mode == 3'd4, "R1 setup fault", mode, 4);
        cmp_en = 1'b0;
        rst_n = 1'b0;
        #1;
        check(mode == 3'd0 && fclr && !latched, "R1 reset from fault", mode, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // Sweeps over every flag combination in several orders
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 1024; i++) begin
                int mul;
                mul = (p == 0) ? 1 : (p == 1) ? 373 : (p == 2) ? 611 : 947;
                drive(10'((i * mul + p * 91) % 1024), (i % 3) + 1);
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_bad++;
                $display("FAIL R1 watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule